// File: doc/BRIEF.md
# Boot Overlay Decoder with Wait Insertion

This block sits between the bus of an 8-bit processor with a 16-bit address space and the memory devices that share the bottom 16 KB of that space. After reset it runs in overlay mode. In that mode a 4 KB boot ROM answers at the bottom of memory and a 1 KB SRAM sits directly above it. The rest of the low 16 KB window returns nothing. DRAM column strobes are held off anywhere below 4000h, and DRAM at 4000h and above works as usual.

Firmware leaves overlay mode with an I/O write to any port in the E0h group (port bits 7..3 = 11100). DRAM then answers across the full 64 KB and the boot devices go quiet. An I/O write to any port in the F0h group (port bits 7..3 = 11110) brings the overlay back. Every access that lands on the ROM or the SRAM is stretched by one wait state, because those parts are slower than the DRAM.

The chip selects and the DRAM column gate are decoded from the bus without a register stage. The mode flag and the wait sequencing are each held in a single register.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: After a synchronous reset the block is in overlay mode. With the bus idle, every output is high (inactive).
- R2: In overlay mode, a memory access to 0000h..0FFFh drives rom_ce_n low and leaves sram_ce_n and cas_en_n high.
- R3: In overlay mode, a memory access to 1000h..13FFh drives sram_ce_n low and leaves rom_ce_n and cas_en_n high.
- R4: In overlay mode, a memory access to 1400h..3FFFh drives no chip select, keeps cas_en_n high and inserts no wait.
- R5: A memory access at 4000h or above drives cas_en_n low in either mode.
- R6: An I/O write whose address bits 7..3 are 11100 leaves overlay mode. Every later access then drives cas_en_n low and never drives rom_ce_n, sram_ce_n or wait_n.
- R7: An I/O write whose address bits 7..3 are 11110 re-enters overlay mode.
- R8: I/O reads and I/O writes to any other port group leave the mode unchanged.
- R9: A ROM or SRAM access holds wait_n low for exactly its first clock cycle and high for the rest of the access. No other access asserts wait_n.
- R10: A refresh cycle (mreq_n low while rd_n, wr_n and m1_n are all high) asserts none of the outputs.
- R11: A new mode is in force for the first memory access that starts in the clock after the I/O write ends.
- R12: A memory access is mreq_n low together with rd_n, wr_n or m1_n low, so opcode fetches decode the same way as reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch cycle marker, active low |
| rom_ce_n | output | 1 | Boot ROM chip enable, active low |
| sram_ce_n | output | 1 | Overlay SRAM chip enable, active low |
| cas_en_n | output | 1 | DRAM column strobe gate, active low (low = DRAM may respond) |
| wait_n | output | 1 | Wait request to the processor, active low |

## Verification
The address map is probed at every region edge (0000h, 0FFFh, 1000h, 13FFh, 1400h, 3FFFh, 4000h, FFFFh) in both modes. These probes separate off-by-one faults in the ROM, SRAM and window compares. Random accesses then mix reads, writes, opcode fetches and refresh cycles with I/O reads and writes, weighted toward the two mode ports and their neighbours. This mix tells the correct port-group match apart from looser or shifted matches, and shows whether a read or a stray port can flip the mode. Each access is held for two clocks, which separates a single wait cycle from a missing or stuck wait. A memory access placed straight after each mode write shows whether the new mode is in force right away.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

    // Decoded bus activity for one clock cycle
    typedef struct packed {
        logic mem_acc;   // memory read, write or opcode fetch
        logic refresh;   // memory request with no strobe
        logic io_wr;     // I/O write (not interrupt acknowledge)
    } bus_cyc_t;

    // Region hit inside the overlay window
    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_SRAM = 2'd1,
        RGN_HOLE = 2'd2,
        RGN_DRAM = 2'd3
    } region_e;

    function automatic bus_cyc_t classify_bus(
        input logic mreq_n, input logic iorq_n,
        input logic rd_n, input logic wr_n, input logic m1_n);
        bus_cyc_t c;
        c.mem_acc = !mreq_n && (!rd_n || !wr_n || !m1_n);
        c.refresh = !mreq_n && rd_n && wr_n && m1_n;
        c.io_wr   = !iorq_n && !wr_n && m1_n;
        return c;
    endfunction

endpackage

// File: rtl/overlay_mode_reg.sv
module overlay_mode_reg
    import boot_overlay_pkg::*;
#(
    parameter int PORT_AW  = 8,
    parameter int GRP_LSB  = 3,
    parameter logic [PORT_AW-1-GRP_LSB:0] GRP_DRAM_ON  = 5'b11100,
    parameter logic [PORT_AW-1-GRP_LSB:0] GRP_DRAM_OFF = 5'b11110
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_wr,
    input  logic [PORT_AW-1:0] port,
    output logic               overlay_q
);
    localparam int GRP_W = PORT_AW - GRP_LSB;

    logic [GRP_W-1:0] grp;
    logic             hit_on;
    logic             hit_off;

    assign grp     = port[PORT_AW-1:GRP_LSB];
    assign hit_on  = io_wr && (grp == GRP_DRAM_ON);
    assign hit_off = io_wr && (grp == GRP_DRAM_OFF);

    always_ff @(posedge clk) begin
        if (rst)          overlay_q <= 1'b1;
        else if (hit_on)  overlay_q <= 1'b0;
        else if (hit_off) overlay_q <= 1'b1;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(hit_on || hit_off) |=> $stable(overlay_q)); // R8
    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (rst)
        hit_on |=> !overlay_q); // R6
    AST_MODE_ENTER: assert property (@(posedge clk) disable iff (rst)
        hit_off |=> overlay_q); // R7

endmodule

// File: rtl/overlay_decoder.sv
module overlay_decoder
    import boot_overlay_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 12,
    parameter int SRAM_AW = 10,
    parameter logic [ADDR_W-1:0] SRAM_BASE = 16'h1000,
    parameter int WIN_AW = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              overlay,
    input  logic              mem_acc,
    output logic              rom_sel,
    output logic              sram_sel,
    output logic              dram_sel
);
    region_e rgn;

    always_comb begin
        if (!overlay || (addr[ADDR_W-1:WIN_AW] != '0))
            rgn = RGN_DRAM;
        else if (addr[ADDR_W-1:ROM_AW] == '0)
            rgn = RGN_ROM;
        else if (addr[ADDR_W-1:SRAM_AW] == SRAM_BASE[ADDR_W-1:SRAM_AW])
            rgn = RGN_SRAM;
        else
            rgn = RGN_HOLE;
    end

    assign rom_sel  = mem_acc && (rgn == RGN_ROM);
    assign sram_sel = mem_acc && (rgn == RGN_SRAM);
    assign dram_sel = mem_acc && (rgn == RGN_DRAM);

    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, sram_sel, dram_sel})); // R2
    AST_NO_BOOT_OUT: assert property (@(posedge clk) disable iff (rst)
        !overlay |-> !(rom_sel || sram_sel)); // R6
    AST_HIGH_DRAM: assert property (@(posedge clk) disable iff (rst)
        (mem_acc && addr[ADDR_W-1:WIN_AW] != '0) |-> dram_sel); // R5

endmodule

// File: rtl/overlay_wait_gen.sv
module overlay_wait_gen (
    input  logic clk,
    input  logic rst,
    input  logic slow_hit,
    input  logic refresh,
    output logic wait_n
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= slow_hit;
    end

    assign wait_n = !(slow_hit && !seen_q);

    AST_ONE_WAIT: assert property (@(posedge clk) disable iff (rst)
        !wait_n |=> wait_n); // R9
    AST_WAIT_SRC: assert property (@(posedge clk) disable iff (rst)
        !wait_n |-> slow_hit); // R9
    AST_RFSH_NOWAIT: assert property (@(posedge clk) disable iff (rst)
        refresh |-> wait_n); // R10

endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
    import boot_overlay_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ROM_AW  = 12,
    parameter int SRAM_AW = 10,
    parameter logic [ADDR_W-1:0] SRAM_BASE = 16'h1000,
    parameter int WIN_AW  = 14,
    parameter int PORT_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              m1_n,
    output logic              rom_ce_n,
    output logic              sram_ce_n,
    output logic              cas_en_n,
    output logic              wait_n
);
    bus_cyc_t cyc;
    logic     overlay_q;
    logic     rom_sel;
    logic     sram_sel;
    logic     dram_sel;

    assign cyc = classify_bus(mreq_n, iorq_n, rd_n, wr_n, m1_n);

    overlay_mode_reg #(
        .PORT_AW (PORT_AW)
    ) mode_i (
        .clk       (clk),
        .rst       (rst),
        .io_wr     (cyc.io_wr),
        .port      (addr[PORT_AW-1:0]),
        .overlay_q (overlay_q)
    );

    overlay_decoder #(
        .ADDR_W    (ADDR_W),
        .ROM_AW    (ROM_AW),
        .SRAM_AW   (SRAM_AW),
        .SRAM_BASE (SRAM_BASE),
        .WIN_AW    (WIN_AW)
    ) dec_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .overlay  (overlay_q),
        .mem_acc  (cyc.mem_acc),
        .rom_sel  (rom_sel),
        .sram_sel (sram_sel),
        .dram_sel (dram_sel)
    );

    overlay_wait_gen wait_i (
        .clk      (clk),
        .rst      (rst),
        .slow_hit (rom_sel || sram_sel),
        .refresh  (cyc.refresh),
        .wait_n   (wait_n)
    );

    assign rom_ce_n  = !rom_sel;
    assign sram_ce_n = !sram_sel;
    assign cas_en_n  = !dram_sel;

    AST_RFSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && rd_n && wr_n && m1_n) |-> (rom_ce_n && sram_ce_n && cas_en_n)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        mreq_n |-> (rom_ce_n && sram_ce_n && cas_en_n && wait_n)); // R1
    AST_BOOT_NO_CAS: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n || !sram_ce_n) |-> cas_en_n); // R5

endmodule

// File: tb/boot_overlay_ctrl_tb.sv
module boot_overlay_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        mreq_n, iorq_n, rd_n, wr_n, m1_n;
    logic        rom_ce_n, sram_ce_n, cas_en_n, wait_n;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  ovl_m;   // bench model of the mode

    always #4 clk = ~clk;

    boot_overlay_ctrl dut_i (
        .clk(clk), .rst(rst), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rom_ce_n(rom_ce_n),
        .sram_ce_n(sram_ce_n), .cas_en_n(cas_en_n), .wait_n(wait_n)
    );

    function automatic bit e_rom(input logic [15:0] a, input bit ovl, input bit acc);
        return acc && ovl && (a < 16'h1000);
    endfunction
    function automatic bit e_sram(input logic [15:0] a, input bit ovl, input bit acc);
        return acc && ovl && (a >= 16'h1000) && (a < 16'h1400);
    endfunction
    function automatic bit e_cas(input logic [15:0] a, input bit ovl, input bit acc);
        return acc && !(ovl && (a < 16'h4000));
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic idle_bus();
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    endtask

    // kind: 0 read, 1 write, 2 opcode fetch, 3 refresh
    task automatic mem_access(input logic [15:0] a, input int kind, input string tag);
        bit acc;
        bit er, es, ec;
        acc = (kind != 3);
        er = e_rom(a, ovl_m, acc);
        es = e_sram(a, ovl_m, acc);
        ec = e_cas(a, ovl_m, acc);
        @(negedge clk);
        addr = a; mreq_n = 1'b0;
        rd_n = !(kind == 0 || kind == 2);
        wr_n = !(kind == 1);
        m1_n = !(kind == 2);
        #1;
        chk(tag, "rom active", !rom_ce_n, er);
        chk(tag, "sram active", !sram_ce_n, es);
        chk(tag, "cas active", !cas_en_n, ec);
        chk((kind == 3) ? "R10" : "R9", "wait first cycle", !wait_n, er || es);
        @(negedge clk);
        #1;
        chk("R9", "wait second cycle", !wait_n, 1'b0);
        chk(tag, "rom held", !rom_ce_n, er);
        chk(tag, "sram held", !sram_ce_n, es);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic io_cycle(input logic [7:0] port, input bit write);
        @(negedge clk);
        addr = {8'($urandom), port};
        iorq_n = 1'b0;
        if (write) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        idle_bus();
        if (write && port[7:3] == 5'b11100) ovl_m = 1'b0;
        if (write && port[7:3] == 5'b11110) ovl_m = 1'b1;
    endtask

    logic [15:0] corners [8] = '{16'h0000, 16'h0FFF, 16'h1000, 16'h13FF,
                                 16'h1400, 16'h3FFF, 16'h4000, 16'hFFFF};

    function automatic string region_tag(input logic [15:0] a);
        if (a < 16'h1000) return "R2";
        if (a < 16'h1400) return "R3";
        if (a < 16'h4000) return "R4";
        return "R5";
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        idle_bus();
        addr = 16'h0;
        rst  = 1'b1;
        ovl_m = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "idle rom", rom_ce_n, 1'b1);
        chk("R1", "idle sram", sram_ce_n, 1'b1);
        chk("R1", "idle cas", cas_en_n, 1'b1);
        chk("R1", "idle wait", wait_n, 1'b1);
        mem_access(16'h0000, 0, "R1");

        // region edges in overlay mode
        foreach (corners[i]) mem_access(corners[i], 0, region_tag(corners[i]));
        mem_access(16'h0800, 2, "R12");
        mem_access(16'h1200, 1, "R3");
        mem_access(16'h0010, 3, "R10");
        mem_access(16'h5000, 3, "R10");

        // ports next to the mode groups do nothing
        io_cycle(8'hE0, 1'b0);
        io_cycle(8'hD8, 1'b1);
        io_cycle(8'hE8, 1'b1);
        io_cycle(8'hF8, 1'b1);
        mem_access(16'h0000, 0, "R8");

        // leave overlay and check right away
        io_cycle(8'hE5, 1'b1);
        mem_access(16'h0000, 0, "R11");
        foreach (corners[i]) mem_access(corners[i], 0, "R6");
        mem_access(16'h1100, 2, "R12");
        io_cycle(8'hF0, 1'b0);
        mem_access(16'h0000, 1, "R8");

        // back into overlay
        io_cycle(8'hF7, 1'b1);
        mem_access(16'h1000, 0, "R11");
        mem_access(16'h0000, 0, "R7");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 7) begin
                logic [15:0] a;
                int r;
                r = int'($urandom % 4);
                case (r)
                    0: a = 16'($urandom % 32'h1000);
                    1: a = 16'h1000 + 16'($urandom % 32'h400);
                    2: a = 16'h1400 + 16'($urandom % 32'h2C00);
                    default: a = 16'($urandom);
                endcase
                mem_access(a, int'($urandom % 4),
                           ovl_m ? region_tag(a) : "R6");
            end else begin
                logic [7:0] p;
                int pr;
                pr = int'($urandom % 4);
                case (pr)
                    0: p = 8'hE0 | 8'($urandom % 8);
                    1: p = 8'hF0 | 8'($urandom % 8);
                    2: p = 8'hC0 | 8'($urandom % 64);
                    default: p = 8'($urandom);
                endcase
                io_cycle(p, ($urandom % 4) != 0);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule